// File: doc/BRIEF.md
# Write-Enabled Master-Slave Storage Cell from Reversible Gates

This block stores a word of bits. Each bit is held in a master-slave cell built only from reversible three-input gates. A controlled-swap gate, steered by the write enable, picks either the incoming data bit or the bit the cell already holds. The picked value feeds a master latch that is open while the clock is low. A slave latch, open while the clock is high, follows it. A double controlled-NOT gate then splits the slave content into a true output and a complement output. The true output is also routed back to the swap gate. Holding a value therefore needs no clock gating: the stored bit simply recirculates.

Each latch is one swap-style reversible gate. Its inputs are, in order, the phase control, the new value and the present state. It computes `next = ctl·new + ctl'·state`. The gate's second result, the value that was not selected, cannot be dropped, because that would break reversibility. Each cell therefore delivers three spill outputs, one from the mux gate and one from each latch. They are brought to ports so that the reversible behaviour of each gate can be observed. Per bit, the gate costs add up to 4 for the mux, 5 for each latch and 2 for the fan-out gate, plus 1 for the feedback copy, which gives 17.

Top module: `rv_we_ff`

## Requirements
- R1: At a rising clock edge with `wr_en` = 1, every bit of `dout` takes the value `din` had at that edge. It then keeps that value until the next rising edge.
- R2: At a rising clock edge with `wr_en` = 0, `dout` keeps its previous value, whatever `din` is.
- R3: `dout` changes only at rising clock edges. Changes of `din` or `wr_en` while the clock is high, or while it is low, do not reach `dout` before the next rising edge.
- R4: `dout_n` is always the bitwise complement of `dout`.
- R5: `spill_mux` carries the input that the mux gate did not select: `dout` when `wr_en` = 1, and `din` when `wr_en` = 0. `spill_mst` carries the selected one: `din` when `wr_en` = 1, and `dout` when `wr_en` = 0.
- R6: `spill_slv` shows the master latch content. While the clock is low it follows the mux selection. While the clock is high it stays frozen at the value it held at the rising edge, which equals `dout`.
- R7: The bits are independent. Each bit of `dout` depends only on the same bit of `din`, so alternating and mixed patterns are stored exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the master latch is open while low, the slave latch while high |
| wr_en | input | 1 | 1: capture `din`; 0: recirculate the stored bits |
| din | input | WIDTH | Data to store |
| dout | output | WIDTH | Stored value |
| dout_n | output | WIDTH | Complement of the stored value |
| spill_mux | output | WIDTH | Unselected output of the mux gate (garbage) |
| spill_mst | output | WIDTH | Second output of the master latch gate (garbage) |
| spill_slv | output | WIDTH | Second output of the slave latch gate (garbage) |

## Verification
Two of this block's functions can fall in the same clock period. One is the master latch tracking new data while the clock is low. The other is the slave latch exposing the previous capture while the clock is high. The bench changes `din` several times inside a single period, in both clock phases and in both write and hold modes. It then checks two things: that only the value present at the rising edge reaches `dout`, and that `spill_slv` follows during the low phase and stays frozen during the high phase. A random stream of enable and data values is also compared cycle by cycle against a plain enabled flip-flop model, including the three spill values and the complement output.

// File: rtl/rvff_pkg.sv
package rvff_pkg;

  // Result of a three-line controlled-swap style gate: the routed value
  // and the value that must be kept for reversibility.
  typedef struct packed {
    logic sel;
    logic spill;
  } swap_out_t;

  // Result of a double controlled-NOT gate used as fan-out.
  typedef struct packed {
    logic keep;
    logic copy;
    logic flip;
  } fan_out_t;

  // Controlled swap: ctl = 1 routes a to sel, otherwise b.
  function automatic swap_out_t cswap(input logic ctl, input logic a, input logic b);
    swap_out_t r;
    r.sel   = (ctl & a) | (~ctl & b);
    r.spill = (ctl & b) | (~ctl & a);
    return r;
  endfunction

  // Double controlled-NOT: targets b and c are each XORed with control a.
  function automatic fan_out_t dcnot(input logic a, input logic b, input logic c);
    fan_out_t r;
    r.keep = a;
    r.copy = a ^ b;
    r.flip = a ^ c;
    return r;
  endfunction

  // Per-gate quantum cost figures and the cell total derived from them.
  localparam int unsigned QC_MUX   = 4;
  localparam int unsigned QC_LATCH = 5;
  localparam int unsigned QC_COPY  = 1;
  localparam int unsigned QC_FAN   = 2;

  function automatic int unsigned cell_cost();
    return QC_MUX + 2 * QC_LATCH + QC_COPY + QC_FAN;
  endfunction

  localparam int unsigned SPILLS_PER_CELL = 3;

endpackage

// File: rtl/rv_swap_mux.sv
module rv_swap_mux
  import rvff_pkg::*;
(
  input  logic pick_new,
  input  logic new_bit,
  input  logic old_bit,
  output logic chosen,
  output logic spill
);

  swap_out_t g;

  always_comb begin
    g      = cswap(pick_new, new_bit, old_bit);
    chosen = g.sel;
    spill  = g.spill;
  end

endmodule

// File: rtl/rv_latch_cell.sv
module rv_latch_cell
  import rvff_pkg::*;
(
  input  logic open_i,
  input  logic data_i,
  output logic state_o,
  output logic spill_o
);

  logic      st;
  swap_out_t g;

  // Storage node: the gate's selected output is written back while open.
  always_latch begin
    if (open_i) st <= data_i;
  end

  always_comb begin
    g       = cswap(open_i, data_i, st);
    spill_o = g.spill;
  end

  assign state_o = st;

endmodule

// File: rtl/rv_fanout.sv
module rv_fanout
  import rvff_pkg::*;
(
  input  logic src,
  output logic true_o,
  output logic comp_o
);

  fan_out_t g;

  always_comb begin
    g      = dcnot(src, 1'b0, 1'b1);
    true_o = g.copy;
    comp_o = g.flip;
  end

endmodule

// File: rtl/rv_bit_cell.sv
module rv_bit_cell (
  input  logic clk,
  input  logic wr_en,
  input  logic din,
  output logic dout,
  output logic dout_n,
  output logic spill_mux,
  output logic spill_mst,
  output logic spill_slv
);

  logic clk_lo;
  logic mux_pick;
  logic mst_state;
  logic slv_state;
  logic fb_bit;

  assign clk_lo = ~clk;

  rv_swap_mux mux_i (
    .pick_new (wr_en),
    .new_bit  (din),
    .old_bit  (fb_bit),
    .chosen   (mux_pick),
    .spill    (spill_mux)
  );

  rv_latch_cell master_i (
    .open_i  (clk_lo),
    .data_i  (mux_pick),
    .state_o (mst_state),
    .spill_o (spill_mst)
  );

  rv_latch_cell slave_i (
    .open_i  (clk),
    .data_i  (mst_state),
    .state_o (slv_state),
    .spill_o (spill_slv)
  );

  rv_fanout fan_i (
    .src    (slv_state),
    .true_o (fb_bit),
    .comp_o (dout_n)
  );

  assign dout = fb_bit;

endmodule

// File: rtl/rv_we_ff.sv
module rv_we_ff #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dout_n,
  output logic [WIDTH-1:0] spill_mux,
  output logic [WIDTH-1:0] spill_mst,
  output logic [WIDTH-1:0] spill_slv
);

  localparam int unsigned TOTAL_SPILLS = WIDTH * rvff_pkg::SPILLS_PER_CELL;
  localparam int unsigned TOTAL_COST   = WIDTH * rvff_pkg::cell_cost();

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    rv_bit_cell cell_i (
      .clk       (clk),
      .wr_en     (wr_en),
      .din       (din[b]),
      .dout      (dout[b]),
      .dout_n    (dout_n[b]),
      .spill_mux (spill_mux[b]),
      .spill_mst (spill_mst[b]),
      .spill_slv (spill_slv[b])
    );
  end

  if (TOTAL_SPILLS != 3 * WIDTH || TOTAL_COST != 17 * WIDTH) begin : g_cost_bad
    initial $error("rv_we_ff: gate accounting mismatch");
  end

endmodule

// File: rtl/rv_we_ff_chk.sv
module rv_we_ff_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             wr_en,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout,
  input logic [WIDTH-1:0] dout_n,
  input logic [WIDTH-1:0] spill_mux,
  input logic [WIDTH-1:0] spill_mst,
  input logic [WIDTH-1:0] spill_slv
);

  logic             armed = 1'b0;
  logic             low_seen = 1'b0;
  logic [WIDTH-1:0] dout_at_fall = '0;

  always_ff @(posedge clk) armed <= armed | wr_en;

  always_ff @(negedge clk) begin
    dout_at_fall <= dout;
    low_seen     <= armed;
  end

  // R1
  a_r1_capture: assert property (@(posedge clk) disable iff (!armed)
    wr_en |=> (dout == $past(din)));

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (!armed)
    !wr_en |=> $stable(dout));

  // R3: nothing moved dout during the low phase just ended
  a_r3_quiet_low: assert property (@(posedge clk) disable iff (!low_seen)
    dout == dout_at_fall);

  // R4
  a_r4_complement: assert property (@(posedge clk) disable iff (!armed)
    dout_n == ~dout);

  // R5
  a_r5_mux_spill: assert property (@(posedge clk) disable iff (!armed)
    (spill_mux == (wr_en ? dout : din)) && (spill_mst == (wr_en ? din : dout)));

  // R6: at the falling edge the master still holds what the slave shows
  a_r6_master_frozen: assert property (@(negedge clk) disable iff (!armed)
    spill_slv == dout);

endmodule

bind rv_we_ff rv_we_ff_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .wr_en     (wr_en),
  .din       (din),
  .dout      (dout),
  .dout_n    (dout_n),
  .spill_mux (spill_mux),
  .spill_mst (spill_mst),
  .spill_slv (spill_slv)
);

// File: tb/rv_we_ff_tb_top.sv
`timescale 1ns/1ps
module rv_we_ff_tb_top;

  localparam int unsigned WB = 4;

  typedef struct {
    logic          w;
    logic [WB-1:0] d;
    logic [WB-1:0] q;
  } exp_t;

  logic          clk = 1'b0;
  logic          wr_en = 1'b1;
  logic [WB-1:0] din = '0;
  logic [WB-1:0] dout, dout_n, spill_mux, spill_mst, spill_slv;

  int unsigned   n_run = 0;
  int unsigned   n_fail = 0;
  logic [WB-1:0] ref_q = '0;
  logic [31:0]   lfsr = 32'hACE1_2468;
  exp_t          sb[$];

  always #2.5 clk = ~clk;

  rv_we_ff #(.WIDTH(WB)) dut_i (
    .clk (clk), .wr_en (wr_en), .din (din), .dout (dout), .dout_n (dout_n),
    .spill_mux (spill_mux), .spill_mst (spill_mst), .spill_slv (spill_slv)
  );

  task automatic chk(input string tag, input logic [WB-1:0] act, input logic [WB-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected outcome.
  task automatic drive(input logic w, input logic [WB-1:0] d);
    exp_t e;
    @(negedge clk);
    wr_en = w;
    din   = d;
    ref_q = w ? d : ref_q;
    e.w = w; e.d = d; e.q = ref_q;
    sb.push_back(e);
  endtask

  // Monitor: compares after each rising edge when an item is due.
  always @(posedge clk) begin
    #1;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.w ? "R1 write" : "R2 hold", dout, e.q);
      chk("R4 complement", dout_n, ~e.q);
      chk("R5 mux spill", spill_mux, e.w ? e.q : e.d);
      chk("R5 master spill", spill_mst, e.w ? e.d : e.q);
      chk("R6 slave spill", spill_slv, e.q);
    end
  end

  // Several data edits inside one period, write mode (R3, R6, R1).
  task automatic glitch_write(input logic [WB-1:0] a, input logic [WB-1:0] b, input logic [WB-1:0] c);
    @(negedge clk);
    wr_en = 1'b1; din = a;
    #1;   chk("R6 master follows low", spill_slv, a);
          chk("R3 no change while low", dout, ref_q);
    din = b;
    #0.5; chk("R6 master follows low", spill_slv, b);
          chk("R3 no change while low", dout, ref_q);
    @(posedge clk); #1;
    chk("R1 edge value taken", dout, b);
    din = c;
    #0.5; chk("R3 no change while high", dout, b);
          chk("R6 master frozen high", spill_slv, b);
    ref_q = b;
  endtask

  // Data edits in hold mode across both phases (R2, R3).
  task automatic glitch_hold(input logic [WB-1:0] a, input logic [WB-1:0] b);
    @(negedge clk);
    wr_en = 1'b0; din = a;
    #1;   chk("R6 master recirculates", spill_slv, ref_q);
    din = b;
    @(posedge clk); #1;
    chk("R2 hold ignores din", dout, ref_q);
    din = ~b; wr_en = 1'b1;
    #0.5; chk("R3 enable while high ignored", dout, ref_q);
  endtask

  initial begin
    // initial load of a known value
    drive(1'b1, 4'h0);
    drive(1'b0, 4'hF);
    // R7: alternating and mixed patterns per bit
    drive(1'b1, 4'h5);
    drive(1'b1, 4'hA);
    drive(1'b1, 4'h6);
    @(negedge clk); chk("R7 bit independence", dout, 4'h6);
    drive(1'b0, 4'h9);
    glitch_write(4'h3, 4'hC, 4'h1);
    glitch_hold(4'hF, 4'h0);
    drive(1'b1, 4'h8);
    glitch_hold(4'h7, 4'h2);
    glitch_write(4'hE, 4'h1, 4'hF);
    // random stream against the enabled flip-flop model (R1, R2)
    for (int i = 0; i < 300; i++) begin
      lfsr = step(lfsr);
      drive(lfsr[7], lfsr[3:0]);
    end
    @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule